// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns a 128-bit or 256-bit cipher key into the complete set of round keys and keeps them in an indexed store. The encryption datapath reads them one at a time by round number. A single-cycle init request loads the key and starts generation. The block then produces one 32-bit schedule word per clock until the whole schedule is stored, and raises ready again. The schedule stays in registers afterwards, so any number of blocks can be enciphered with it without a new expansion.

The block owns no substitution boxes. For the SubWord step it borrows a four-byte S-box lookup port that it shares with the encryption datapath. In every cycle where it needs the substitution it raises a request, presents a word and takes back the substituted word in the same cycle. Because the port is shared, expansion and block processing must never overlap. The request is only ever raised while ready is low.

Top module: `aes_keysched`

## Requirements
- R1: Out of reset, ready_o is 1, sbox_req_o is 0 and every round key read through rk_idx_i/rk_o is all zeros.
- R2: An init_i pulse sampled while ready_o is 1 makes ready_o drop after that edge. ready_o then stays low for exactly 40 cycles with wide_i=0, or 52 cycles with wide_i=1, and rises back to 1.
- R3: With wide_i=0 only key_i[255:128] is used, and key_i[127:0] has no effect. Round keys 0..10 match the standard 128-bit schedule, and round key 0 equals key_i[255:128].
- R4: With wide_i=1 all 256 key bits are used and round keys 0..14 match the standard 256-bit schedule. Round key 0 equals key_i[255:128] and round key 1 equals key_i[127:0].
- R5: Round constants are applied in the order 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. Each value is the previous one doubled in GF(2^8) with reduction by 1B, and each sits in the most significant byte of the word.
- R6: In 256-bit mode, every word whose index is 4 modulo 8 passes through SubWord with no rotation and no round constant.
- R7: sbox_req_o is high only in cycles that need SubWord, and only while ready_o is 0. That is 10 cycles per 128-bit expansion and 13 cycles per 256-bit expansion. sbox_in_o carries the rotated previous word in cycles that apply a round constant.
- R8: An init_i pulse that arrives while ready_o is 0 is ignored. This holds even in the final generation cycle. Expansion finishes on its original schedule, with the original key and length, and ready_o stays 1 afterwards.
- R9: While ready_o stays 1, rk_o depends only on rk_idx_i, which is read combinationally. Changes to key_i or wide_i without init_i do not alter the stored schedule.
- R10: rk_o carries the lowest-numbered word of the selected round key in bits [127:96]. Within each word, the first key byte is in the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start expansion (accepted only while ready) |
| wide_i | input | 1 | Key length select: 0 = 128-bit, 1 = 256-bit |
| key_i | input | 256 | Cipher key, first byte in bits [255:248] |
| sbox_req_o | output | 1 | Shared S-box port claimed this cycle |
| sbox_in_o | output | 32 | Word presented to the four S-box lookups |
| sbox_out_i | input | 32 | Substituted word returned in the same cycle |
| rk_idx_i | input | 4 | Round-key number to read |
| rk_o | output | 128 | Selected round key |
| ready_o | output | 1 | Idle with a complete schedule (or reset state) |

## Verification
Two functions can meet in one cycle: a fresh init request and the write of the final schedule word, which also releases ready. The bench raises init_i together with a different key and the other length at the negedge before that last generation edge, and again in the middle of a run. It then judges by the exact low time of ready_o, by ready_o staying high afterwards, and by the scoreboard comparing every round key against the original key's schedule. A reference model built from a computed S-box drives the lookup port and supplies the expected round keys. Published end-of-schedule values are checked as well.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

   localparam int WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   // cyclic left rotation by one byte
   function automatic word_t rot_byte(input word_t w);
      return {w[23:0], w[31:24]};
   endfunction

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_dbl(input logic [7:0] b);
      return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
   endfunction

endpackage

// File: rtl/aes_ks_rcon.sv
module aes_ks_rcon
   import aes_ks_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       step,
   output logic [7:0] rcon
);

   logic [7:0] rc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rc_q <= 8'h01;
      else if (load) rc_q <= 8'h01;
      else if (step) rc_q <= gf_dbl(rc_q);
   end

   assign rcon = rc_q;

endmodule

// File: rtl/aes_ks_wordgen.sv
module aes_ks_wordgen
   import aes_ks_pkg::*;
(
   input  word_t      w_prev,
   input  word_t      w_back,
   input  logic [7:0] rcon,
   input  logic       use_rcon,
   input  logic       use_sub,
   output word_t      sbox_in,
   input  word_t      sbox_out,
   output word_t      new_word
);

   word_t mix;

   always_comb begin
      sbox_in = use_rcon ? rot_byte(w_prev) : w_prev;
      if (use_sub)
         mix = sbox_out ^ (use_rcon ? {rcon, 24'h0} : '0);
      else
         mix = w_prev;
      new_word = w_back ^ mix;
   end

endmodule

// File: rtl/aes_ks_store.sv
module aes_ks_store
   import aes_ks_pkg::*;
#(
   parameter int NRK    = 15,
   parameter int RD_REG = 0,
   localparam int NW    = 4 * NRK,
   localparam int AW    = $clog2(NW),
   localparam int IW    = $clog2(NRK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_wide,
   input  word_t [7:0]       ld_words,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  word_t             wr_data,
   input  logic [IW-1:0]     rd_idx,
   output logic [4*WORD_W-1:0] rd_key
);

   word_t mem [NW];
   logic [4*WORD_W-1:0] rd_comb;

   for (genvar j = 0; j < NW; j++) begin : g_word
      if (j < 8) begin : g_keyslot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem[j] <= '0;
            else if (ld_en && (j < 4 || ld_wide))   mem[j] <= ld_words[j];
            else if (wr_en && wr_addr == AW'(j))    mem[j] <= wr_data;
         end
      end else begin : g_genslot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem[j] <= '0;
            else if (wr_en && wr_addr == AW'(j))    mem[j] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_comb = '0;
      for (int k = 0; k < 4; k++) begin
         if (int'(rd_idx) < NRK)
            rd_comb[(3-k)*WORD_W +: WORD_W] = mem[AW'(int'(rd_idx) * 4 + k)];
      end
   end

   if (RD_REG != 0) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_key <= '0;
         else        rd_key <= rd_comb;
      end
   end else begin : g_rd_comb
      assign rd_key = rd_comb;
   end

endmodule

// File: rtl/aes_keysched.sv
module aes_keysched
   import aes_ks_pkg::*;
#(
   parameter int KEY_W      = 256,
   parameter int NR128_KEYS = 11,
   parameter int NR256_KEYS = 15,
   parameter int RD_REG     = 0,
   localparam int NW        = 4 * NR256_KEYS,
   localparam int AW        = $clog2(NW),
   localparam int IW        = $clog2(NR256_KEYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_i,
   input  logic               wide_i,
   input  logic [KEY_W-1:0]   key_i,
   output logic               sbox_req_o,
   output logic [WORD_W-1:0]  sbox_in_o,
   input  logic [WORD_W-1:0]  sbox_out_i,
   input  logic [IW-1:0]      rk_idx_i,
   output logic [4*WORD_W-1:0] rk_o,
   output logic               ready_o
);

   localparam logic [AW-1:0] LAST_N = AW'(4 * NR128_KEYS - 1);
   localparam logic [AW-1:0] LAST_W = AW'(NW - 1);

   if (KEY_W != 8 * WORD_W) begin : g_chk_key
      $error("aes_keysched: KEY_W must be 256");
   end
   if (NR128_KEYS != 11 || NR256_KEYS != 15) begin : g_chk_rounds
      $error("aes_keysched: round-key counts must be 11 and 15");
   end
   if (RD_REG != 0 && RD_REG != 1) begin : g_chk_rd
      $error("aes_keysched: RD_REG must be 0 or 1");
   end

   word_t [7:0]   kw;
   word_t [7:0]   win_q;
   logic          busy_q, wide_q;
   logic [AW-1:0] idx_q;
   logic          start, use_rcon, use_sub, last;
   logic [7:0]    rcon;
   word_t         w_back, new_word;

   for (genvar j = 0; j < 8; j++) begin : g_kw
      assign kw[j] = key_i[KEY_W-1-WORD_W*j -: WORD_W];
   end

   assign start    = init_i && !busy_q;
   assign use_rcon = busy_q && (wide_q ? (idx_q[2:0] == 3'd0) : (idx_q[1:0] == 2'd0));
   assign use_sub  = use_rcon || (busy_q && wide_q && idx_q[2:0] == 3'd4);
   assign last     = idx_q == (wide_q ? LAST_W : LAST_N);
   assign w_back   = wide_q ? win_q[0] : win_q[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wide_q <= 1'b0;
         idx_q  <= '0;
         win_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         wide_q <= wide_i;
         idx_q  <= wide_i ? AW'(8) : AW'(4);
         win_q  <= wide_i ? kw : {kw[3:0], {4{32'h0}}};
      end else if (busy_q) begin
         win_q <= {new_word, win_q[7:1]};
         idx_q <= idx_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

   aes_ks_rcon u_rcon (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (use_rcon),
      .rcon  (rcon)
   );

   aes_ks_wordgen u_gen (
      .w_prev   (win_q[7]),
      .w_back   (w_back),
      .rcon     (rcon),
      .use_rcon (use_rcon),
      .use_sub  (use_sub),
      .sbox_in  (sbox_in_o),
      .sbox_out (sbox_out_i),
      .new_word (new_word)
   );

   aes_ks_store #(.NRK(NR256_KEYS), .RD_REG(RD_REG)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (start),
      .ld_wide  (wide_i),
      .ld_words (kw),
      .wr_en    (busy_q),
      .wr_addr  (idx_q),
      .wr_data  (new_word),
      .rd_idx   (rk_idx_i),
      .rd_key   (rk_o)
   );

   assign sbox_req_o = use_sub;
   assign ready_o    = !busy_q;

endmodule

// File: rtl/aes_keysched_chk.sv
module aes_keysched_chk (
   input logic         clk,
   input logic         rst_n,
   input logic         init_i,
   input logic         sbox_req_o,
   input logic [3:0]   rk_idx_i,
   input logic [127:0] rk_o,
   input logic         ready_o
);

   // R2
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> $past(init_i));

   // R2
   init_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && init_i) |=> !ready_o);

   // R7
   sbox_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sbox_req_o |-> !ready_o);

   // R9
   hold_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && $past(ready_o) && $stable(rk_idx_i)) |-> $stable(rk_o));

endmodule

bind aes_keysched aes_keysched_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_i     (init_i),
   .sbox_req_o (sbox_req_o),
   .rk_idx_i   (rk_idx_i),
   .rk_o       (rk_o),
   .ready_o    (ready_o)
);

// File: tb/aes_keysched_test.sv
module aes_keysched_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init_i = 1'b0;
   logic         wide_i = 1'b0;
   logic [255:0] key_i = '0;
   logic         sbox_req_o;
   logic [31:0]  sbox_in_o;
   logic [31:0]  sbox_out_i;
   logic [3:0]   rk_idx_i = '0;
   logic [127:0] rk_o;
   logic         ready_o;

   int total = 0;
   int bad = 0;

   typedef struct {
      string        tag;
      int           idx;
      logic [127:0] val;
   } item_t;
   item_t sb_q[$];

   logic [31:0] exp_w [60];

   always #4 clk = ~clk;

   aes_keysched uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_i),
      .wide_i     (wide_i),
      .key_i      (key_i),
      .sbox_req_o (sbox_req_o),
      .sbox_in_o  (sbox_in_o),
      .sbox_out_i (sbox_out_i),
      .rk_idx_i   (rk_idx_i),
      .rk_o       (rk_o),
      .ready_o    (ready_o)
   );

   // ---------------- reference arithmetic ----------------
   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      end
      return p;
   endfunction

   function automatic logic [7:0] sb(input logic [7:0] v);
      logic [7:0] inv = 8'h00;
      logic [7:0] r;
      for (int c = 1; c < 256; c++)
         if (gmul(v, 8'(c)) == 8'h01) inv = 8'(c);
      r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      return r;
   endfunction

   function automatic logic [31:0] subw(input logic [31:0] w);
      return {sb(w[31:24]), sb(w[23:16]), sb(w[15:8]), sb(w[7:0])};
   endfunction

   // shared S-box port model
   always_comb sbox_out_i = subw(sbox_in_o);

   task automatic ref_expand(input logic [255:0] k, input logic wide);
      int nk = wide ? 8 : 4;
      int nw = wide ? 60 : 44;
      logic [7:0]  rc = 8'h01;
      logic [31:0] t;
      for (int i = 0; i < nk; i++) exp_w[i] = k[255-32*i -: 32];
      for (int i = nk; i < nw; i++) begin
         t = exp_w[i-1];
         if (i % nk == 0) begin
            t  = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
            rc = gmul(rc, 8'h02);
         end else if (nk == 8 && i % 8 == 4) begin
            t = subw(t);
         end
         exp_w[i] = exp_w[i-nk] ^ t;
      end
   endtask

   function automatic logic [127:0] exp_rk(input int r);
      return {exp_w[4*r], exp_w[4*r+1], exp_w[4*r+2], exp_w[4*r+3]};
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push(input string tag, input int idx, input logic [127:0] val);
      item_t it;
      it.tag = tag; it.idx = idx; it.val = val;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: pops expected round keys and compares the read port
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            rk_idx_i = 4'(it.idx);
            #1;
            check(it.tag, rk_o, it.val);
         end
      end
   end

   // driver: start expansion, measure ready low time and S-box claims
   task automatic run_exp(input logic [255:0] k, input logic wide, input bit disturb,
                          output int low, output int sreq);
      int exp_low = wide ? 52 : 40;
      low = 0; sreq = 0;
      @(negedge clk);
      key_i = k; wide_i = wide; init_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0;
      while (!ready_o && low < 200) begin
         low++;
         if (sbox_req_o) sreq++;
         if (disturb && (low == 10 || low == exp_low)) begin
            init_i = 1'b1; key_i = ~k; wide_i = ~wide;
         end else begin
            init_i = 1'b0;
         end
         @(negedge clk);
      end
      init_i = 1'b0;
   endtask

   // watchdog
   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int low, sreq;
      logic [255:0] ka, kb, kc;
      ka = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'hdeadbeef_0badf00d_12345678_9abcdef0};
      kb = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
      kc = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ready", {127'h0, ready_o}, 128'h1);
      check("R1 sbox_req", {127'h0, sbox_req_o}, 128'h0);
      push("R1 rk0 zero", 0, '0);
      push("R1 rk14 zero", 14, '0);
      drain();
      rst_n = 1'b1;
      @(negedge clk);

      // 128-bit expansion, lower key half is junk (R3)
      run_exp(ka, 1'b0, 1'b0, low, sreq);
      check("R2 low cycles 128", 128'(low), 128'd40);
      check("R7 sbox claims 128", 128'(sreq), 128'd10);
      ref_expand(ka, 1'b0);
      for (int r = 0; r < 11; r++) push("R3 rk 128", r, exp_rk(r));
      push("R10 rk0 order", 0, ka[255:128]);
      push("R5 rk10 published", 10, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
      drain();

      // 256-bit expansion
      run_exp(kb, 1'b1, 1'b0, low, sreq);
      check("R2 low cycles 256", 128'(low), 128'd52);
      check("R7 sbox claims 256", 128'(sreq), 128'd13);
      ref_expand(kb, 1'b1);
      for (int r = 0; r < 15; r++) push("R4 rk 256", r, exp_rk(r));
      push("R4 rk1 key low half", 1, kb[127:0]);
      push("R6 rk14 published", 14, 128'h24fc79ccbf0979e9371ac23c6d68de36);
      drain();

      // second 128-bit vector, reading rounds in reverse
      run_exp(kc, 1'b0, 1'b0, low, sreq);
      ref_expand(kc, 1'b0);
      for (int r = 10; r >= 0; r--) push("R3 rk 128 rev", r, exp_rk(r));
      push("R5 rk10 second", 10, 128'h13111d7fe3944a17f307a78b4d2b30c5);
      drain();

      // R8: init during expansion, including the final generation cycle
      run_exp(ka, 1'b0, 1'b1, low, sreq);
      check("R8 low cycles undisturbed", 128'(low), 128'd40);
      repeat (5) begin
         @(negedge clk);
         check("R8 ready stays high", {127'h0, ready_o}, 128'h1);
      end
      ref_expand(ka, 1'b0);
      for (int r = 0; r < 11; r++) push("R8 schedule kept", r, exp_rk(r));
      drain();

      // R9: key and length changes without init leave the schedule alone
      key_i = kb; wide_i = 1'b1;
      repeat (10) @(negedge clk);
      for (int r = 0; r < 11; r++) push("R9 schedule held", r, exp_rk(r));
      push("R9 repeat read", 10, exp_rk(10));
      drain();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule